// File: doc/BRIEF.md
# Operand Forwarding Unit

This block selects bypass sources for the execute stage of a five-stage in-order pipeline. Each cycle it compares the two source register numbers of the instruction in execute against the destination registers of the two older instructions. The older instructions sit in the memory stage and in the write-back stage. From that comparison it picks, for each ALU operand, one of three values: the value read from the register file, the memory-stage result or the write-back value. The chosen operand values are produced combinationally, in the same cycle as the select codes.

The block also bypasses around the register file for the decode-stage read ports. A read that targets the register being written back in the same cycle returns the value being written instead of the stale stored value. Register 0 always reads as zero, and a write to register 0 is never forwarded. The ALU, the register storage and stall generation sit outside this block.

Top module: `fwd_unit`

## Requirements
- R1: When the memory stage writes (mem_wen=1) a nonzero mem_dst equal to ex_src_a, sel_a is 2'b10 and ex_opnd_a equals mem_result.
- R2: When the write-back stage writes (wb_wen=1) a nonzero wb_dst equal to ex_src_a and R1's condition is false, sel_a is 2'b01 and ex_opnd_a equals wb_data.
- R3: Operand B is selected by the R1/R2 rules applied to ex_src_b, independently of operand A; sel_b and ex_opnd_b follow.
- R4: When both stages match the same nonzero source, the memory-stage result wins (select 2'b10).
- R5: A destination of register 0 is never forwarded: the select stays 2'b00 even when enables are set and numbers match.
- R6: A stage whose write enable is 0 is never forwarded from, whatever its destination.
- R7: With no forwarding condition, the select is 2'b00 and the operand equals the register-file value (ex_rf_a / ex_rf_b); the code 2'b11 never appears.
- R8: A decode read (id_raddr_a or id_raddr_b) of a nonzero register that write-back writes this cycle returns wb_data.
- R9: A decode read of register 0 returns zero, whatever the raw data and write-back state.
- R10: A decode read of a nonzero register with no matching write-back write returns the raw register-file data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | 5 | Execute-stage source register A |
| ex_src_b | input | 5 | Execute-stage source register B |
| ex_rf_a | input | 32 | Register-file value captured for A |
| ex_rf_b | input | 32 | Register-file value captured for B |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_dst | input | 5 | Memory-stage destination register |
| mem_result | input | 32 | Memory-stage ALU result |
| wb_wen | input | 1 | Write-back stage writes a register |
| wb_dst | input | 5 | Write-back destination register |
| wb_data | input | 32 | Write-back value |
| id_raddr_a | input | 5 | Decode read address, port A |
| id_raddr_b | input | 5 | Decode read address, port B |
| id_raw_a | input | 32 | Raw stored data for port A |
| id_raw_b | input | 32 | Raw stored data for port B |
| sel_a | output | 2 | Operand A source select |
| sel_b | output | 2 | Operand B source select |
| ex_opnd_a | output | 32 | Selected operand A |
| ex_opnd_b | output | 32 | Selected operand B |
| id_rdata_a | output | 32 | Bypassed decode read, port A |
| id_rdata_b | output | 32 | Bypassed decode read, port B |

## Verification
The selection logic is driven with patterns where only the memory stage matches, only write-back matches, both match one source, and A and B match different stages. These patterns separate correct priority from a swapped or merged comparison. Patterns with a zero destination or a cleared enable but equal register numbers show whether either qualifier has been dropped. The decode bypass is tried with a matching write, a disabled write, a mismatched address and register 0 with nonzero raw data. These tell the write-through path apart from a plain pass-through and from a missing zero clamp.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  parameter int REG_W  = 5;
  parameter int DATA_W = 32;
  localparam int NUM_OPS = 2;

  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_WB  = 2'b01,
    SRC_MEM = 2'b10
  } src_sel_e;

  // A producer stage supplies a value for a source when it writes a nonzero matching register
  function automatic logic producer_hit(input logic wen, input logic [REG_W-1:0] dst,
                                        input logic [REG_W-1:0] src);
    return wen && (dst != '0) && (dst == src);
  endfunction

  function automatic src_sel_e pick_source(input logic mem_hit, input logic wb_hit);
    if (mem_hit)     return SRC_MEM;
    else if (wb_hit) return SRC_WB;
    else             return SRC_RF;
  endfunction
endpackage

// File: rtl/fwd_select.sv
module fwd_select
  import fwd_pkg::*;
(
  input  logic [REG_W-1:0] src,
  input  logic             mem_wen,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             wb_wen,
  input  logic [REG_W-1:0] wb_dst,
  output src_sel_e         sel
);
  logic mem_hit, wb_hit;

  always_comb begin
    mem_hit = producer_hit(mem_wen, mem_dst, src);
    wb_hit  = producer_hit(wb_wen, wb_dst, src);
    sel     = pick_source(mem_hit, wb_hit);
    // R5
    r5_zero_src_chk: assert (src != '0 || sel == SRC_RF);
    // R4
    r4_mem_first_chk: assert (!(mem_wen && mem_dst == src && src != '0) || sel == SRC_MEM);
    // R6
    r6_wen_gate_chk: assert (mem_wen || wb_wen || sel == SRC_RF);
  end
endmodule

// File: rtl/fwd_opmux.sv
module fwd_opmux
  import fwd_pkg::*;
(
  input  src_sel_e          sel,
  input  logic [DATA_W-1:0] rf_val,
  input  logic [DATA_W-1:0] mem_val,
  input  logic [DATA_W-1:0] wb_val,
  output logic [DATA_W-1:0] opnd
);
  always_comb begin
    unique case (sel)
      SRC_MEM: opnd = mem_val;
      SRC_WB:  opnd = wb_val;
      default: opnd = rf_val;
    endcase
    // R7
    r7_code_chk: assert (sel != 2'b11);
  end
endmodule

// File: rtl/rf_bypass.sv
module rf_bypass
  import fwd_pkg::*;
(
  input  logic [REG_W-1:0]  raddr,
  input  logic [DATA_W-1:0] raw,
  input  logic              wb_wen,
  input  logic [REG_W-1:0]  wb_dst,
  input  logic [DATA_W-1:0] wb_data,
  output logic [DATA_W-1:0] rdata
);
  logic wt_hit;

  always_comb begin
    wt_hit = producer_hit(wb_wen, wb_dst, raddr);
    if (raddr == '0)  rdata = '0;
    else if (wt_hit)  rdata = wb_data;
    else              rdata = raw;
    // R9
    r9_zero_read_chk: assert (raddr != '0 || rdata == '0);
  end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
(
  input  logic [4:0]  ex_src_a,
  input  logic [4:0]  ex_src_b,
  input  logic [31:0] ex_rf_a,
  input  logic [31:0] ex_rf_b,
  input  logic        mem_wen,
  input  logic [4:0]  mem_dst,
  input  logic [31:0] mem_result,
  input  logic        wb_wen,
  input  logic [4:0]  wb_dst,
  input  logic [31:0] wb_data,
  input  logic [4:0]  id_raddr_a,
  input  logic [4:0]  id_raddr_b,
  input  logic [31:0] id_raw_a,
  input  logic [31:0] id_raw_b,
  output logic [1:0]  sel_a,
  output logic [1:0]  sel_b,
  output logic [31:0] ex_opnd_a,
  output logic [31:0] ex_opnd_b,
  output logic [31:0] id_rdata_a,
  output logic [31:0] id_rdata_b
);
  logic [REG_W-1:0]  src_v   [NUM_OPS];
  logic [DATA_W-1:0] rf_v    [NUM_OPS];
  src_sel_e          sel_v   [NUM_OPS];
  logic [DATA_W-1:0] opnd_v  [NUM_OPS];
  logic [REG_W-1:0]  raddr_v [NUM_OPS];
  logic [DATA_W-1:0] raw_v   [NUM_OPS];
  logic [DATA_W-1:0] rd_v    [NUM_OPS];

  assign src_v[0] = ex_src_a;   assign src_v[1] = ex_src_b;
  assign rf_v[0]  = ex_rf_a;    assign rf_v[1]  = ex_rf_b;
  assign raddr_v[0] = id_raddr_a; assign raddr_v[1] = id_raddr_b;
  assign raw_v[0] = id_raw_a;   assign raw_v[1] = id_raw_b;

  // R1 R2 R3: one selector and one mux per operand, independent of each other
  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    fwd_select u_sel (
      .src(src_v[g]), .mem_wen(mem_wen), .mem_dst(mem_dst),
      .wb_wen(wb_wen), .wb_dst(wb_dst), .sel(sel_v[g])
    );
    fwd_opmux u_mux (
      .sel(sel_v[g]), .rf_val(rf_v[g]), .mem_val(mem_result),
      .wb_val(wb_data), .opnd(opnd_v[g])
    );
    // R8 R10: write-through around the register file for each decode read port
    rf_bypass u_byp (
      .raddr(raddr_v[g]), .raw(raw_v[g]), .wb_wen(wb_wen),
      .wb_dst(wb_dst), .wb_data(wb_data), .rdata(rd_v[g])
    );
  end

  assign sel_a      = sel_v[0];
  assign sel_b      = sel_v[1];
  assign ex_opnd_a  = opnd_v[0];
  assign ex_opnd_b  = opnd_v[1];
  assign id_rdata_a = rd_v[0];
  assign id_rdata_b = rd_v[1];
endmodule

// File: tb/fwd_unit_tb.sv
module fwd_unit_tb_top;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic [4:0]  ex_src_a, ex_src_b, mem_dst, wb_dst, id_raddr_a, id_raddr_b;
  logic [31:0] ex_rf_a, ex_rf_b, mem_result, wb_data, id_raw_a, id_raw_b;
  logic        mem_wen, wb_wen;
  logic [1:0]  sel_a, sel_b;
  logic [31:0] ex_opnd_a, ex_opnd_b, id_rdata_a, id_rdata_b;

  fwd_unit dut_i (.*);

  int checks = 0, errors = 0;

  // {src_a, src_b, mem_wen, mem_dst, wb_wen, wb_dst, exp_sel_a, exp_sel_b}
  localparam int NV = 8;
  localparam logic [25:0] VEC [NV] = '{
    {5'd3,  5'd4,  1'b1, 5'd3,  1'b1, 5'd4,  2'b10, 2'b01},
    {5'd3,  5'd3,  1'b1, 5'd3,  1'b1, 5'd3,  2'b10, 2'b10},
    {5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 5'd0,  2'b00, 2'b00},
    {5'd5,  5'd6,  1'b0, 5'd5,  1'b0, 5'd6,  2'b00, 2'b00},
    {5'd7,  5'd8,  1'b1, 5'd8,  1'b1, 5'd7,  2'b01, 2'b10},
    {5'd9,  5'd9,  1'b0, 5'd9,  1'b1, 5'd9,  2'b01, 2'b01},
    {5'd2,  5'd1,  1'b1, 5'd4,  1'b1, 5'd5,  2'b00, 2'b00},
    {5'd31, 5'd31, 1'b1, 5'd31, 1'b0, 5'd31, 2'b10, 2'b10}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_opnd(input logic [1:0] s, input logic [31:0] rf);
    if (s == 2'b10) return mem_result;
    if (s == 2'b01) return wb_data;
    return rf;
  endfunction

  initial begin
    ex_src_a = 0; ex_src_b = 0; mem_dst = 0; wb_dst = 0; id_raddr_a = 0; id_raddr_b = 0;
    ex_rf_a = 32'h1111_0000; ex_rf_b = 32'h2222_0000; mem_result = 32'hAAAA_5555;
    wb_data = 32'h5A5A_A5A5; id_raw_a = 0; id_raw_b = 0; mem_wen = 0; wb_wen = 0;
    repeat (2) @(posedge clk);
    rst_n = 1;
    @(posedge clk); #1;
    // reset/idle state, R7
    check("R7 idle sel_a", {30'd0, sel_a}, 0);
    check("R7 idle sel_b", {30'd0, sel_b}, 0);
    check("R7 idle opnd_a", ex_opnd_a, 32'h1111_0000);
    check("R9 idle rdata_a", id_rdata_a, 0);

    // R1 R2 R3 R4 R5 R6 R7 vector walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {ex_src_a, ex_src_b, mem_wen, mem_dst, wb_wen, wb_dst} = VEC[i][25:4];
      ex_rf_a = 32'hA000_0000 + i; ex_rf_b = 32'hB000_0000 + i;
      mem_result = 32'hC000_0000 + i; wb_data = 32'hD000_0000 + i;
      @(posedge clk); #1;
      check($sformatf("R1 R2 R4 R5 R6 sel_a vec%0d", i), {30'd0, sel_a}, {30'd0, VEC[i][3:2]});
      check($sformatf("R3 R4 R5 R6 sel_b vec%0d", i), {30'd0, sel_b}, {30'd0, VEC[i][1:0]});
      check($sformatf("R7 opnd_a vec%0d", i), ex_opnd_a, expect_opnd(VEC[i][3:2], ex_rf_a));
      check($sformatf("R7 opnd_b vec%0d", i), ex_opnd_b, expect_opnd(VEC[i][1:0], ex_rf_b));
    end

    // R8 / R10: write-through on port A, plain read on port B
    @(negedge clk);
    wb_wen = 1; wb_dst = 6; wb_data = 32'h1234_5678;
    id_raddr_a = 6; id_raw_a = 32'hDEAD_0006; id_raddr_b = 7; id_raw_b = 32'hDEAD_0007;
    @(posedge clk); #1;
    check("R8 write-through port A", id_rdata_a, 32'h1234_5678);
    check("R10 mismatch port B", id_rdata_b, 32'hDEAD_0007);
    // R8 on port B
    @(negedge clk); id_raddr_b = 6;
    @(posedge clk); #1;
    check("R8 write-through port B", id_rdata_b, 32'h1234_5678);
    // R10: write disabled
    @(negedge clk); wb_wen = 0;
    @(posedge clk); #1;
    check("R10 disabled write port A", id_rdata_a, 32'hDEAD_0006);
    // R9: register 0 with write to r0 and nonzero raw
    @(negedge clk); wb_wen = 1; wb_dst = 0; id_raddr_a = 0; id_raw_a = 32'hFFFF_FFFF;
    @(posedge clk); #1;
    check("R9 zero read port A", id_rdata_a, 0);
    @(negedge clk); wb_wen = 0; id_raddr_b = 0; id_raw_b = 32'h0000_0001;
    @(posedge clk); #1;
    check("R9 zero read port B", id_rdata_b, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule